// File: doc/BRIEF.md
# Soft Mute Gain Ramp for a Stereo Sample Stream

This block fades a stereo stream of signed samples in and out without clicks. It steps its gain once per output frame, and a one-cycle frame strobe marks each frame. While the mute request is high, the gain falls by one step per frame until the output is silent. While the request is low, the gain climbs by one step per frame back to unity. Going from unity to silence, or from silence to unity, takes 1024 frames.

The request may change at any frame. The ramp then turns around at the gain it has already reached, so a mute that is cancelled early recovers over only as many frames as it spent falling. Each output sample is the input sample times the gain, divided by the ramp length and truncated toward zero. Two status flags report full silence and the settled unmuted state.

Top module: `soft_mute_ramp`

## Requirements
- R1: Synchronous active-high reset sets the gain to unity (1024) and both output samples to zero. At any time, the gain value never exceeds 1024.
- R2: The gain and both output samples change only on a clock edge where `frame_tick` is high. On other edges they hold, whatever the inputs do.
- R3: While `mute_req` is high, each frame strobe lowers the gain by exactly one until it reaches 0. Further strobes leave it at 0.
- R4: While `mute_req` is low, each frame strobe raises the gain by exactly one until it reaches 1024. Further strobes leave it at 1024.
- R5: A full ramp takes exactly 1024 frame strobes, both from unity to zero and from zero to unity.
- R6: When `mute_req` changes during a ramp, the next strobe steps the gain by one from its current value in the new direction. The ramp does not restart.
- R7: On a frame strobe, each output register loads the matching input sample times the gain held before that strobe, divided by 1024 and truncated toward zero. Samples and outputs are two's complement, 24 bits by default. For example, -1 at gain 512 gives 0 and -3 at gain 512 gives -1.
- R8: `muted` is high exactly when the gain is 0. It can only become high while a mute is requested.
- R9: `idle` is high exactly when the gain is 1024 and `mute_req` is low.
- R10: At unity gain each output equals its input sample exactly. At zero gain each output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle strobe per output frame; steps the gain and loads the outputs |
| mute_req | input | 1 | High requests a fade to silence, low requests a fade to unity |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| out_left | output | DATA_W | Left scaled sample, signed, registered |
| out_right | output | DATA_W | Right scaled sample, signed, registered |
| gain | output | GAIN_W | Current gain, 0 to RAMP_LEN |
| muted | output | 1 | Gain is zero |
| idle | output | 1 | Gain is unity and no mute is requested |

## Verification
The bound checker watches every cycle and covers these properties:
- the gain stays in range;
- the gain holds between strobes;
- the gain takes single steps in the direction the request selects;
- outputs are silenced at zero gain and passed through unchanged at unity;
- the status flags stay consistent with the request.

Some behaviours only the bench scenarios can show. These are the exact truncated products at intermediate gains, including the rounding of negative samples toward zero. They also include the 1024-strobe length of each full ramp, the turnaround of a cancelled mute at the gain already reached, and a reset that arrives in the middle of a ramp.

// File: rtl/soft_mute_pkg.sv
package soft_mute_pkg;

    localparam int SM_DATA_W   = 24;
    localparam int SM_RAMP_LEN = 1024;
    localparam int SM_NUM_CH   = 2;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } step_e;

    // Direction of the next gain step; a reversal simply picks the other
    // direction from wherever the counter currently sits.
    function automatic step_e pick_step(input logic req,
                                        input logic at_floor,
                                        input logic at_ceil);
        if (req)
            return at_floor ? STEP_HOLD : STEP_DOWN;
        return at_ceil ? STEP_HOLD : STEP_UP;
    endfunction

endpackage

// File: rtl/soft_mute_gain.sv
module soft_mute_gain
    import soft_mute_pkg::*;
#(
    parameter int RAMP_LEN = SM_RAMP_LEN,
    parameter int GAIN_W   = $clog2(RAMP_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic              mute_req,
    output logic [GAIN_W-1:0] gain,
    output logic              at_floor,
    output logic              at_ceil
);

    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(RAMP_LEN);
    localparam logic [GAIN_W-1:0] ONE   = GAIN_W'(1);

    step_e step;

    assign at_floor = (gain == '0);
    assign at_ceil  = (gain == UNITY);

    always_comb begin
        step = pick_step(mute_req, at_floor, at_ceil);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain <= UNITY;
        end else if (frame_tick) begin
            unique case (step)
                STEP_DOWN: gain <= gain - ONE;
                STEP_UP:   gain <= gain + ONE;
                default:   gain <= gain;
            endcase
        end
    end

endmodule

// File: rtl/soft_mute_scale.sv
module soft_mute_scale #(
    parameter int DATA_W   = 24,
    parameter int RAMP_LEN = 1024,
    parameter int GAIN_W   = $clog2(RAMP_LEN) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic signed [DATA_W-1:0] sample,
    input  logic        [GAIN_W-1:0] gain,
    output logic signed [DATA_W-1:0] scaled
);

    localparam int SHIFT  = $clog2(RAMP_LEN);
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] BIAS = PROD_W'((64'd1 << SHIFT) - 64'd1);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    logic signed [DATA_W-1:0] scaled_d;

    always_comb begin
        prod     = PROD_W'(sample) * PROD_W'($signed({1'b0, gain}));
        // Adding (2^SHIFT - 1) to negative products turns the arithmetic
        // shift into a division that truncates toward zero.
        biased   = prod[PROD_W-1] ? (prod + BIAS) : prod;
        scaled_d = DATA_W'(biased >>> SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst)
            scaled <= '0;
        else if (load)
            scaled <= scaled_d;
    end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
    import soft_mute_pkg::*;
#(
    parameter  int DATA_W   = SM_DATA_W,
    parameter  int RAMP_LEN = SM_RAMP_LEN,
    localparam int GAIN_W   = $clog2(RAMP_LEN) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_tick,
    input  logic                     mute_req,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right,
    output logic        [GAIN_W-1:0] gain,
    output logic                     muted,
    output logic                     idle
);

    logic at_floor;
    logic at_ceil;
    logic signed [DATA_W-1:0] ch_in  [SM_NUM_CH];
    logic signed [DATA_W-1:0] ch_out [SM_NUM_CH];

    soft_mute_gain #(
        .RAMP_LEN (RAMP_LEN),
        .GAIN_W   (GAIN_W)
    ) u_gain (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .mute_req   (mute_req),
        .gain       (gain),
        .at_floor   (at_floor),
        .at_ceil    (at_ceil)
    );

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    for (genvar c = 0; c < SM_NUM_CH; c++) begin : g_chan
        soft_mute_scale #(
            .DATA_W   (DATA_W),
            .RAMP_LEN (RAMP_LEN),
            .GAIN_W   (GAIN_W)
        ) u_scale (
            .clk    (clk),
            .rst    (rst),
            .load   (frame_tick),
            .sample (ch_in[c]),
            .gain   (gain),
            .scaled (ch_out[c])
        );
    end

    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];
    assign muted     = at_floor;
    assign idle      = at_ceil & ~mute_req;

endmodule

// File: rtl/soft_mute_ramp_chk.sv
module soft_mute_ramp_chk #(
    parameter  int DATA_W   = 24,
    parameter  int RAMP_LEN = 1024,
    localparam int GAIN_W   = $clog2(RAMP_LEN) + 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     frame_tick,
    input logic                     mute_req,
    input logic signed [DATA_W-1:0] in_left,
    input logic signed [DATA_W-1:0] in_right,
    input logic signed [DATA_W-1:0] out_left,
    input logic signed [DATA_W-1:0] out_right,
    input logic        [GAIN_W-1:0] gain,
    input logic                     muted,
    input logic                     idle
);

    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(RAMP_LEN);
    localparam logic [GAIN_W-1:0] ONE   = GAIN_W'(1);

    logic seen_rst = 1'b0;
    logic prev_ok  = 1'b0;

    always_ff @(posedge clk) begin
        seen_rst <= seen_rst | rst;
        prev_ok  <= seen_rst | rst;
    end

    p_gain_range_r1: assert property (@(posedge clk) disable iff (rst)
        seen_rst |-> gain <= UNITY);

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !$past(rst) && !$past(frame_tick))
        |-> ($stable(gain) && $stable(out_left) && $stable(out_right)));

    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !$past(rst) && $past(frame_tick) && $past(mute_req) && $past(gain) != '0)
        |-> gain == $past(gain) - ONE);

    p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !$past(rst) && $past(frame_tick) && !$past(mute_req) && $past(gain) != UNITY)
        |-> gain == $past(gain) + ONE);

    p_muted_by_request_r8: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !$past(rst) && $rose(muted)) |-> $past(mute_req));

    p_idle_consistent_r9: assert property (@(posedge clk) disable iff (rst)
        (seen_rst && idle) |-> (!mute_req && !muted && gain == UNITY));

    p_zero_gain_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !$past(rst) && $past(frame_tick) && $past(gain) == '0)
        |-> (out_left == '0 && out_right == '0));

    p_unity_passthrough_r10: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !$past(rst) && $past(frame_tick) && $past(gain) == UNITY)
        |-> (out_left == $past(in_left) && out_right == $past(in_right)));

endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(
    .DATA_W   (DATA_W),
    .RAMP_LEN (RAMP_LEN)
) u_chk (.*);

// File: tb/soft_mute_ramp_test.sv
module soft_mute_ramp_test;

    localparam int DW   = 24;
    localparam int FULL = 1024;
    localparam int GW   = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_tick = 1'b0;
    logic mute_req = 1'b0;
    logic signed [DW-1:0] in_left  = '0;
    logic signed [DW-1:0] in_right = '0;
    logic signed [DW-1:0] out_left;
    logic signed [DW-1:0] out_right;
    logic [GW-1:0] gain;
    logic muted;
    logic idle;

    int checks = 0;
    int errors = 0;
    int gain_m = FULL;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    soft_mute_ramp #(.DATA_W(DW), .RAMP_LEN(FULL)) uut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .mute_req(mute_req),
        .in_left(in_left), .in_right(in_right),
        .out_left(out_left), .out_right(out_right),
        .gain(gain), .muted(muted), .idle(idle)
    );

    // {left, right} pairs, walked at whatever gain the ramp holds.
    localparam logic [2*DW-1:0] VEC [8] = '{
        {24'h7FFFFF, 24'h800000},
        {24'h000001, 24'hFFFFFF},
        {24'h123456, 24'hEDCBAA},
        {24'h000000, 24'h400000},
        {24'hFFFFFD, 24'h000003},
        {24'h3FF000, 24'hC01000},
        {24'h000400, 24'hFFFC00},
        {24'h555555, 24'hAAAAAA}
    };

    function automatic longint scale(input longint s, input int g);
        return (s * g) / FULL;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic frame(input logic signed [DW-1:0] l, input logic signed [DW-1:0] r);
        int g0;
        g0 = gain_m;
        @(negedge clk);
        in_left = l; in_right = r; frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        if (mute_req) begin
            if (gain_m > 0) gain_m--;
        end else begin
            if (gain_m < FULL) gain_m++;
        end
        chk("R7 left",  longint'(out_left),  scale(longint'(l), g0));
        chk("R7 right", longint'(out_right), scale(longint'(r), g0));
        chk("R3/R4/R6 gain", longint'(gain), longint'(gain_m));
        chk("R8 muted", longint'(muted), longint'(gain_m == 0));
        chk("R9 idle",  longint'(idle),  longint'(gain_m == FULL && !mute_req));
    endtask

    function automatic logic signed [DW-1:0] pat(input int k);
        return DW'(k * 40503 + 12345);
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
    end

    initial begin
        int n;
        logic signed [DW-1:0] hl, hr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 gain", longint'(gain), FULL);
        chk("R1 out", longint'(out_left), 0);
        chk("R1 idle", longint'(idle), 1);
        chk("R1 muted", longint'(muted), 0);

        // R10: table at unity gain, passthrough
        for (int i = 0; i < 8; i++) begin
            frame(VEC[i][2*DW-1:DW], VEC[i][DW-1:0]);
            chk("R10 unity", longint'(out_left), longint'($signed(VEC[i][2*DW-1:DW])));
        end

        // R9: request high at unity clears idle
        @(negedge clk);
        mute_req = 1'b1;
        #1;
        chk("R9 idle with request", longint'(idle), 0);

        // R2: no strobe, inputs change, nothing moves
        hl = out_left; hr = out_right;
        in_left = 24'h111111; in_right = 24'h222222;
        repeat (5) @(negedge clk);
        chk("R2 gain hold", longint'(gain), FULL);
        chk("R2 left hold", longint'(out_left), longint'(hl));
        chk("R2 right hold", longint'(out_right), longint'(hr));

        // R3: ramp down part way, then walk the table at mid gain
        for (int k = 0; k < 300; k++) frame(pat(k), -pat(k));
        for (int i = 0; i < 8; i++) frame(VEC[i][2*DW-1:DW], VEC[i][DW-1:0]);

        // R6: reverse mid ramp
        n = gain_m;
        mute_req = 1'b0;
        frame(pat(1), pat(2));
        chk("R6 turnaround", longint'(gain), longint'(n + 1));
        for (int k = 0; k < 99; k++) frame(pat(k + 7), pat(k + 9));
        chk("R6 climb", longint'(gain), longint'(n + 100));
        while (gain_m < FULL) frame(pat(gain_m), -pat(gain_m));
        chk("R9 idle restored", longint'(idle), 1);

        // R7: negative truncation at gain 512
        mute_req = 1'b1;
        while (gain_m > 512) frame(pat(gain_m), pat(gain_m + 1));
        frame(-24'sd1, -24'sd3);
        chk("R7 trunc -1", longint'(out_left), 0);
        chk("R7 trunc -3", longint'(out_right), -1);
        mute_req = 1'b0;
        while (gain_m < FULL) frame(pat(gain_m), pat(gain_m));

        // R5: full ramp down is 1024 strobes
        mute_req = 1'b1;
        n = 0;
        while (!muted && n < 2000) begin
            frame(pat(n), -pat(n));
            n++;
        end
        chk("R5 down length", n, FULL);

        // R3/R8/R10: hold at zero
        for (int k = 0; k < 5; k++) frame(24'h7FFFFF, 24'h800000);
        chk("R10 silent", longint'(out_left), 0);
        chk("R8 muted held", longint'(muted), 1);

        // R5/R4: full ramp up is 1024 strobes
        mute_req = 1'b0;
        n = 0;
        while (!idle && n < 2000) begin
            frame(pat(n + 3), pat(n + 5));
            n++;
        end
        chk("R5 up length", n, FULL);
        frame(24'h000123, 24'hFFFEDD);
        chk("R4 saturate", longint'(gain), FULL);

        // R1: reset mid ramp
        mute_req = 1'b1;
        for (int k = 0; k < 10; k++) frame(pat(k), pat(k));
        @(negedge clk);
        rst = 1'b1;
        mute_req = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        gain_m = FULL;
        chk("R1 mid-ramp gain", longint'(gain), FULL);
        chk("R1 mid-ramp out", longint'(out_right), 0);

        summary();
    end

endmodule